// File: doc/BRIEF.md
# T1 Frame Slip Buffer

This block is a controlled-slip elastic store between a received T1 payload stream and a local system timebase. The receive side presents one line bit per bit strobe, together with a frame-start flag that marks the framing bit. The framing bit is dropped and the following 192 payload bits (24 channels of 8 bits) are written as one frame. The system side pulls channel octets on its own octet strobe, with a frame-start flag on channel 0.

When the two timebases drift, the store never hands out a mixture of two frames. If the line outruns the system, a completed frame that was never read is thrown away and the deletion counter steps. If the system outruns the line, the frame last read is read again and the repetition counter steps. Both counters saturate. Each counter is compared with a maintenance limit and an out-of-service limit that software provides on input pins, and the comparisons drive four alarm outputs. A synchronous clear pulse zeroes both counters.

Both timebases arrive as enable strobes on one core clock. A T1 line runs at 1.544 Mbit/s (8000 frames of 193 bits per second), far below any core clock.

Top module: `t1_slip_buffer`

## Requirements
- R1: After reset, octetValid is low, both slip counters read 0 and the reader is idle: an octet strobe without sysFrameStart gives no octet until the first read frame start.
- R2: A line bit that arrives with lineFrameStart is the framing bit and is not stored. The next 192 line bits are payload bit 0..191. Payload bit k belongs to channel k/8, and the first bit of each channel is bit 7 (MSB) of its octet.
- R3: An octet strobe with sysFrameStart reads channel 0 and each later strobe reads the next channel up to 23. Each octet appears on octetData with octetValid high in the cycle after its strobe. Strobes beyond channel 23 and cycles without a strobe leave octetValid low, and sysFrameStart without sysOctetEn is ignored.
- R4: At each read frame start, the reader switches to the newest complete frame that has not been read. All 24 octets of that read frame come from this one written frame.
- R5: If no new complete frame exists at a read frame start, the previously read frame is read again and repCount increments. The frame held after reset is all zeros.
- R6: If a frame completes while an earlier complete frame is still unread, the earlier frame is discarded and delCount increments.
- R7: A lineFrameStart before bit 191 of a frame has arrived discards the partial frame without counting a slip, and writing restarts at payload bit 0.
- R8: When the last payload bit of a frame and a read frame start fall in the same cycle, that read frame delivers the frame just completed and no slip is counted.
- R9: Each counter saturates at 255.
- R10: A slipClear pulse makes both counters 0 in the next cycle, even if a slip happens in the same cycle.
- R11: delMaintAlarm is high while delCount >= maintLimit and delOosAlarm is high while delCount >= oosLimit. repMaintAlarm and repOosAlarm follow repCount against the same two limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineBitEn | input | 1 | Strobe: one received line bit this cycle |
| lineBit | input | 1 | Received line bit value |
| lineFrameStart | input | 1 | The strobed bit is the framing bit |
| sysOctetEn | input | 1 | Strobe: system side takes one channel octet |
| sysFrameStart | input | 1 | The strobed octet is channel 0 of a new read frame |
| maintLimit | input | 8 | Maintenance alarm limit |
| oosLimit | input | 8 | Out-of-service alarm limit |
| slipClear | input | 1 | Synchronous clear of both counters |
| octetValid | output | 1 | octetData carries a new channel octet |
| octetData | output | 8 | Channel octet, MSB received first |
| delCount | output | 8 | Deletion slip count |
| repCount | output | 8 | Repetition slip count |
| delMaintAlarm | output | 1 | Deletion count at or above maintenance limit |
| delOosAlarm | output | 1 | Deletion count at or above out-of-service limit |
| repMaintAlarm | output | 1 | Repetition count at or above maintenance limit |
| repOosAlarm | output | 1 | Repetition count at or above out-of-service limit |

## Verification
Single frames with known channel values, written and then read at matched rates, show the bit-to-octet mapping and the choice of frame. Back-to-back writes with no read, reads with no write, a frame cut short by an early framing bit, and a completion that lands on the read frame start each separate deletion, repetition, abandonment and the same-cycle rule. Long streams with random payload and a reader slightly faster and then slightly slower than the line produce slips at uneven phases. Repeated read starts drive the repetition counter to saturation and through every alarm threshold, and a clear that lands on a slip shows that the clear takes precedence.

// File: rtl/t1sb_pkg.sv
`timescale 1ns/1ps
package t1sb_pkg;
  // three frame slots: one being read, one complete and waiting, one filling
  localparam int NUM_SLOTS = 3;
  typedef logic [1:0] slot_t;

  // datapath -> control events
  typedef struct packed {
    logic frameDone;
    logic readStart;
  } evt_t;

  // control -> datapath slot selects
  typedef struct packed {
    slot_t wrSlot;
    slot_t rdSel;
  } sel_t;
endpackage

// File: rtl/t1sb_store.sv
`timescale 1ns/1ps
module t1sb_store
  import t1sb_pkg::*;
#(
  parameter int CHANNELS  = 24,
  parameter int CHAN_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineBitEn,
  input  logic                 lineBit,
  input  logic                 lineFrameStart,
  input  logic                 sysOctetEn,
  input  logic                 sysFrameStart,
  input  sel_t                 sel,
  output evt_t                 evt,
  output logic                 octetValid,
  output logic [CHAN_BITS-1:0] octetData
);
  localparam int FRAME_BITS = CHANNELS * CHAN_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam int CH_W       = $clog2(CHANNELS + 1);

  logic [FRAME_BITS-1:0] store [NUM_SLOTS];
  logic [POS_W-1:0]      wrPos;
  logic [CH_W-1:0]       chan;
  logic                  wrBit;

  assign wrBit = lineBitEn && !lineFrameStart && (wrPos < POS_W'(FRAME_BITS));

  // write position: FRAME_BITS means idle until the next framing bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPos <= POS_W'(FRAME_BITS);
    end else if (lineBitEn) begin
      if (lineFrameStart)  wrPos <= '0;
      else if (wrBit)      wrPos <= wrPos + POS_W'(1);
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  store[s] <= '0;
      else if (wrBit && sel.wrSlot == slot_t'(s)) store[s][wrPos] <= lineBit;
    end
  end

  assign evt.frameDone = wrBit && (wrPos == POS_W'(FRAME_BITS - 1));
  assign evt.readStart = sysOctetEn && sysFrameStart;

  // read side
  logic [FRAME_BITS-1:0] rdFrame;
  logic [CH_W-1:0]       rdChan;
  logic [POS_W-1:0]      rdBase;
  logic [CHAN_BITS-1:0]  rdSlice, rdOctet;
  logic                  rdFire;

  always_comb begin
    rdFrame = store[0];
    for (int s = 1; s < NUM_SLOTS; s++)
      if (sel.rdSel == slot_t'(s)) rdFrame = store[s];
  end

  assign rdChan  = sysFrameStart ? '0 : chan;
  assign rdFire  = sysOctetEn && (sysFrameStart || chan < CH_W'(CHANNELS));
  assign rdBase  = POS_W'(rdChan) * POS_W'(CHAN_BITS);
  assign rdSlice = rdFrame[rdBase +: CHAN_BITS];

  always_comb begin
    for (int i = 0; i < CHAN_BITS; i++) rdOctet[CHAN_BITS-1-i] = rdSlice[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chan       <= CH_W'(CHANNELS);
      octetValid <= 1'b0;
      octetData  <= '0;
    end else begin
      octetValid <= rdFire;
      if (rdFire) begin
        octetData <= rdOctet;
        chan      <= rdChan + CH_W'(1);
      end
    end
  end
endmodule

// File: rtl/t1sb_ctrl.sv
`timescale 1ns/1ps
module t1sb_ctrl
  import t1sb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  evt_t             evt,
  input  logic             slipClear,
  input  logic [CNT_W-1:0] maintLimit,
  input  logic [CNT_W-1:0] oosLimit,
  output sel_t             sel,
  output logic [CNT_W-1:0] delCount,
  output logic [CNT_W-1:0] repCount,
  output logic             delMaintAlarm,
  output logic             delOosAlarm,
  output logic             repMaintAlarm,
  output logic             repOosAlarm
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic  ready, readyN, delHit, repHit;
  slot_t readySlot, readySlotN, rdSlot, rdSlotN, wrSlot, wrSlotN;

  function automatic slot_t pickFree(slot_t a, slot_t b);
    slot_t r;
    r = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (slot_t'(s) != a && slot_t'(s) != b) r = slot_t'(s);
    return r;
  endfunction

  // completion is applied before the read decision of the same cycle
  always_comb begin
    readyN     = ready;
    readySlotN = readySlot;
    rdSlotN    = rdSlot;
    wrSlotN    = wrSlot;
    delHit     = 1'b0;
    repHit     = 1'b0;
    if (evt.frameDone) begin
      delHit     = ready;
      readyN     = 1'b1;
      readySlotN = wrSlot;
    end
    if (evt.readStart) begin
      if (readyN) begin
        rdSlotN = readySlotN;
        readyN  = 1'b0;
      end else begin
        repHit = 1'b1;
      end
    end
    if (evt.frameDone) wrSlotN = pickFree(rdSlotN, readyN ? readySlotN : rdSlotN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready     <= 1'b0;
      readySlot <= slot_t'(0);
      rdSlot    <= slot_t'(0);
      wrSlot    <= slot_t'(1);
      delCount  <= '0;
      repCount  <= '0;
    end else begin
      ready     <= readyN;
      readySlot <= readySlotN;
      rdSlot    <= rdSlotN;
      wrSlot    <= wrSlotN;
      if (slipClear)                          delCount <= '0;
      else if (delHit && delCount != CNT_MAX) delCount <= delCount + CNT_W'(1);
      if (slipClear)                          repCount <= '0;
      else if (repHit && repCount != CNT_MAX) repCount <= repCount + CNT_W'(1);
    end
  end

  assign sel.wrSlot    = wrSlot;
  assign sel.rdSel     = rdSlotN;
  assign delMaintAlarm = delCount >= maintLimit;
  assign delOosAlarm   = delCount >= oosLimit;
  assign repMaintAlarm = repCount >= maintLimit;
  assign repOosAlarm   = repCount >= oosLimit;
endmodule

// File: rtl/t1_slip_buffer.sv
`timescale 1ns/1ps
module t1_slip_buffer
  import t1sb_pkg::*;
#(
  parameter int CHANNELS  = 24,
  parameter int CHAN_BITS = 8,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineBitEn,
  input  logic                 lineBit,
  input  logic                 lineFrameStart,
  input  logic                 sysOctetEn,
  input  logic                 sysFrameStart,
  input  logic [CNT_W-1:0]     maintLimit,
  input  logic [CNT_W-1:0]     oosLimit,
  input  logic                 slipClear,
  output logic                 octetValid,
  output logic [CHAN_BITS-1:0] octetData,
  output logic [CNT_W-1:0]     delCount,
  output logic [CNT_W-1:0]     repCount,
  output logic                 delMaintAlarm,
  output logic                 delOosAlarm,
  output logic                 repMaintAlarm,
  output logic                 repOosAlarm
);
  evt_t evt;
  sel_t sel;

  t1sb_store #(.CHANNELS(CHANNELS), .CHAN_BITS(CHAN_BITS)) u_store (
    .clk(clk), .rstN(rstN),
    .lineBitEn(lineBitEn), .lineBit(lineBit), .lineFrameStart(lineFrameStart),
    .sysOctetEn(sysOctetEn), .sysFrameStart(sysFrameStart),
    .sel(sel), .evt(evt),
    .octetValid(octetValid), .octetData(octetData)
  );

  t1sb_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .slipClear(slipClear),
    .maintLimit(maintLimit), .oosLimit(oosLimit), .sel(sel),
    .delCount(delCount), .repCount(repCount),
    .delMaintAlarm(delMaintAlarm), .delOosAlarm(delOosAlarm),
    .repMaintAlarm(repMaintAlarm), .repOosAlarm(repOosAlarm)
  );
endmodule

// File: rtl/t1sb_checker.sv
`timescale 1ns/1ps
module t1sb_checker
  import t1sb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sysOctetEn,
  input logic             sysFrameStart,
  input logic             slipClear,
  input logic             octetValid,
  input logic [CNT_W-1:0] delCount,
  input logic [CNT_W-1:0] repCount,
  input evt_t             evt,
  input sel_t             sel
);
  p_read_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sysOctetEn && sysFrameStart) |=> octetValid);

  p_no_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sysOctetEn |=> !octetValid);

  p_slots_apart_r4: assert property (@(posedge clk) disable iff (!rstN)
    !evt.frameDone |-> (sel.wrSlot != sel.rdSel));

  p_del_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    !slipClear |=> (delCount == $past(delCount)) || (delCount == $past(delCount) + CNT_W'(1)));

  p_rep_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !slipClear |=> (repCount == $past(repCount)) || (repCount == $past(repCount) + CNT_W'(1)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    slipClear |=> (delCount == '0) && (repCount == '0));

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (repCount == '1 && !slipClear) |=> (repCount == '1));
endmodule

bind t1_slip_buffer t1sb_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .sysOctetEn(sysOctetEn), .sysFrameStart(sysFrameStart),
  .slipClear(slipClear), .octetValid(octetValid), .delCount(delCount),
  .repCount(repCount), .evt(evt), .sel(sel)
);

// File: tb/t1_slip_buffer_bench.sv
`timescale 1ns/1ps
module t1_slip_buffer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineBitEn = 0, lineBit = 0, lineFrameStart = 0;
  logic sysOctetEn = 0, sysFrameStart = 0, slipClear = 0;
  logic [7:0] maintLimit = 8'd4, oosLimit = 8'd16;
  logic octetValid;
  logic [7:0] octetData, delCount, repCount;
  logic delMaintAlarm, delOosAlarm, repMaintAlarm, repOosAlarm;

  t1_slip_buffer u_t1_slip_buffer (
    .clk(clk), .rstN(rstN), .lineBitEn(lineBitEn), .lineBit(lineBit),
    .lineFrameStart(lineFrameStart), .sysOctetEn(sysOctetEn),
    .sysFrameStart(sysFrameStart), .maintLimit(maintLimit), .oosLimit(oosLimit),
    .slipClear(slipClear), .octetValid(octetValid), .octetData(octetData),
    .delCount(delCount), .repCount(repCount), .delMaintAlarm(delMaintAlarm),
    .delOosAlarm(delOosAlarm), .repMaintAlarm(repMaintAlarm), .repOosAlarm(repOosAlarm)
  );

  always #2 clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   wq[$];
  bit   wAct = 0, pendV = 0, done;
  bit   curF [192];
  bit   pendF[192];
  int   mChan = 24, mDel = 0, mRep = 0, mValid = 0, mData = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      wq.delete(); wAct = 0; pendV = 0; mChan = 24;
      mDel = 0; mRep = 0; mValid = 0; mData = 0;
      foreach (curF[k]) curF[k] = 0;
    end else begin
      done = 0;
      if (lineBitEn) begin
        if (lineFrameStart) begin wq.delete(); wAct = 1; end
        else if (wAct) begin
          wq.push_back(lineBit);
          if (wq.size() == 192) begin done = 1; wAct = 0; end
        end
      end
      if (done) begin
        if (pendV && mDel < 255) mDel++;
        foreach (pendF[k]) pendF[k] = wq[k];
        pendV = 1;
        wq.delete();
      end
      mValid = 0;
      if (sysOctetEn) begin
        if (sysFrameStart) begin
          if (pendV) begin curF = pendF; pendV = 0; end
          else if (mRep < 255) mRep++;
          mChan = 0;
        end
        if (mChan < 24) begin
          mValid = 1;
          mData = 0;
          for (int i = 0; i < 8; i++) mData = (mData << 1) | int'(curF[mChan*8+i]);
          mChan++;
        end
      end
      if (slipClear) begin mDel = 0; mRep = 0; end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      check("R3 octetValid", int'(octetValid), mValid);
      check("R4 octetData", int'(octetData), mData);
      check("R6 delCount", int'(delCount), mDel);
      check("R5 repCount", int'(repCount), mRep);
      check("R11 delMaintAlarm", int'(delMaintAlarm), int'(mDel >= int'(maintLimit)));
      check("R11 delOosAlarm", int'(delOosAlarm), int'(mDel >= int'(oosLimit)));
      check("R11 repMaintAlarm", int'(repMaintAlarm), int'(mRep >= int'(maintLimit)));
      check("R11 repOosAlarm", int'(repOosAlarm), int'(mRep >= int'(oosLimit)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    lineBitEn = 0; lineFrameStart = 0; lineBit = 0;
    sysOctetEn = 0; sysFrameStart = 0; slipClear = 0;
  endtask

  // framing bit, then nBits payload bits; channel c carries base+c, MSB first
  task automatic writeFrame(input logic [7:0] base, input int nBits, input bit readAtEnd);
    logic [7:0] b;
    lineBitEn = 1; lineFrameStart = 1; lineBit = 1; tick();
    lineFrameStart = 0;
    for (int k = 0; k < nBits; k++) begin
      b = base + 8'(k / 8);
      lineBit = b[7 - (k % 8)];
      if (readAtEnd && k == nBits - 1) begin sysOctetEn = 1; sysFrameStart = 1; end
      tick();
      sysOctetEn = 0; sysFrameStart = 0;
    end
    idle();
  endtask

  logic [7:0] rd [24];

  task automatic readOctets(input int first);
    for (int i = first; i < 24; i++) begin
      sysOctetEn = 1; sysFrameStart = (i == 0);
      tick();
      rd[i] = octetData;
    end
    idle();
  endtask

  task automatic stream(input int cycles, input int octPer);
    int lineIdx, octIdx;
    lineIdx = 0; octIdx = 0;
    for (int c = 0; c < cycles; c++) begin
      lineBitEn = (c % 2 == 0);
      lineFrameStart = lineBitEn && (lineIdx % 193 == 0);
      lineBit = 1'($urandom);
      if (lineBitEn) lineIdx++;
      sysOctetEn = (c % octPer == 0);
      sysFrameStart = sysOctetEn && (octIdx % 24 == 0);
      if (sysOctetEn) octIdx++;
      tick();
    end
    idle();
  endtask

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1: reset state, and a strobe without frame start yields no octet
    check("R1 delCount", int'(delCount), 0);
    check("R1 repCount", int'(repCount), 0);
    check("R1 octetValid", int'(octetValid), 0);
    sysOctetEn = 1; tick(); idle();
    check("R1 idle reader", int'(octetValid), 0);
    // R3: frame start flag without strobe is ignored
    sysFrameStart = 1; tick(); idle();
    check("R3 lone frame start", int'(octetValid), 0);

    // R2 / R4: one frame written, then read
    writeFrame(8'h30, 192, 0);
    readOctets(0);
    check("R2 channel 0", int'(rd[0]), 'h30);
    check("R2 channel 5", int'(rd[5]), 'h35);
    check("R4 channel 23", int'(rd[23]), 'h47);
    check("R4 no slip", int'(repCount) + int'(delCount), 0);
    // R3: strobe beyond channel 23
    sysOctetEn = 1; tick(); idle();
    check("R3 past last channel", int'(octetValid), 0);

    // R5: read again with nothing new
    readOctets(0);
    check("R5 repeat count", int'(repCount), 1);
    check("R5 repeated data", int'(rd[7]), 'h37);

    // R6: two frames written before a read
    writeFrame(8'h50, 192, 0);
    writeFrame(8'h70, 192, 0);
    readOctets(0);
    check("R6 deletion count", int'(delCount), 1);
    check("R6 newest frame", int'(rd[2]), 'h72);

    // R7: partial frame abandoned
    writeFrame(8'h90, 50, 0);
    writeFrame(8'hA0, 192, 0);
    readOctets(0);
    check("R7 no deletion", int'(delCount), 1);
    check("R7 no repetition", int'(repCount), 1);
    check("R7 data", int'(rd[10]), 'hAA);

    // R8: completion on the read frame start
    writeFrame(8'hB0, 192, 1);
    rd[0] = octetData;
    readOctets(1);
    check("R8 data ch0", int'(rd[0]), 'hB0);
    check("R8 data ch23", int'(rd[23]), 'hC7);
    check("R8 no repetition", int'(repCount), 1);
    check("R8 no deletion", int'(delCount), 1);

    // R10: clear
    slipClear = 1; tick(); idle();
    check("R10 cleared del", int'(delCount), 0);
    check("R10 cleared rep", int'(repCount), 0);

    // R5: reader faster than line
    stream(15000, 15);
    check("R5 fast reader repeats", int'(repCount > 0), 1);
    slipClear = 1; tick(); idle();
    // R6: reader slower than line
    stream(22000, 17);
    check("R6 slow reader deletes", int'(delCount > 0), 1);
    check("R11 del alarm vs count", int'(delMaintAlarm), int'(delCount >= 8'd4));

    // R9 / R11: saturation through repeated read starts
    slipClear = 1; tick(); idle();
    for (int n = 0; n < 300; n++) begin
      sysOctetEn = 1; sysFrameStart = 1; tick();
    end
    idle(); tick();
    check("R9 saturated", int'(repCount), 255);
    check("R11 rep maint", int'(repMaintAlarm), 1);
    check("R11 rep oos", int'(repOosAlarm), 1);
    check("R11 del maint", int'(delMaintAlarm), 0);
    oosLimit = 8'd255; tick();
    check("R11 rep oos at 255", int'(repOosAlarm), 1);
    maintLimit = 8'd0; tick();
    check("R11 del maint limit 0", int'(delMaintAlarm), 1);
    maintLimit = 8'd4; oosLimit = 8'd16;

    // R10: clear wins over a simultaneous repetition
    slipClear = 1; sysOctetEn = 1; sysFrameStart = 1; tick(); idle();
    check("R10 clear beats slip", int'(repCount), 0);
    tick();
    check("R10 stays clear", int'(repCount), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule